// File: doc/BRIEF.md
# Configurable Registered I/O Cell

This block is one programmable pad cell that sits between a device pin and the core logic. Static configuration bits pick its behaviour. It can pass the pad straight into the core, drive the pad straight from the core, capture either direction in a storage element, or act as a bidirectional pin. The pad is modelled as three plain wires: `pad_in` (value seen at the pin), `pad_out` (value to drive) and `pad_oe` (driver enable).

None of the cell's control functions has a dedicated wire. Clock, clock enable, output enable, reset and preset each come from one bit of a shared control bus. That bus is split into four quadrants, and each quadrant serves the cells on one edge of the device. A cell chooses its quadrant once. Each of its five control functions then picks a bit inside that quadrant with its own select field and passes through its own inversion bit.

Because the clock enable is one of those selectable functions, the cell can skip clock edges without any gating of the clock itself. The storage element can be set up as an edge-triggered register or as a level-sensitive latch.

Top module: `io_cell`

## Requirements
- R1: With `cfg_mode` 0 (combinational input), and also with the unused codes 5, 6 and 7, `core_in` equals `pad_in`, while `pad_out` and `pad_oe` are both 0.
- R2: With `cfg_mode` 1 (combinational output), `pad_out` equals `core_out`, `pad_oe` equals the effective output enable, and `core_in` is 0.
- R3: With `cfg_mode` 2 (registered input) and `cfg_latch` 0, the stored bit takes `pad_in` on each rising edge of the effective clock while the effective clock enable is 1. `core_in` shows the stored bit, and `pad_out` and `pad_oe` are 0.
- R4: With `cfg_mode` 3 (registered output), the stored bit takes `core_out` under the same rule. `pad_out` shows the stored bit, `pad_oe` equals the effective output enable, and `core_in` is 0.
- R5: With `cfg_mode` 4 (bidirectional), `core_in` always equals `pad_in`, `pad_out` equals `core_out`, and `pad_oe` equals the effective output enable.
- R6: With `cfg_latch` 1, the stored bit follows its data input for as long as both the effective clock and the effective clock enable are 1. At all other times it holds.
- R7: While the effective clock enable is 0, a rising effective clock edge leaves the stored bit unchanged.
- R8: While the effective reset is 1, the stored bit is 0 at once, without waiting for a clock. It stays 0 even if the effective preset is also 1.
- R9: While the effective preset is 1 and the effective reset is 0, the stored bit is 1 at once.
- R10: Each control function's effective value is its selected bus bit XOR its own inversion bit. For example, with `cfg_clk_inv` 1, capture happens on a falling edge of the selected bus bit.
- R11: Control bits are taken only from the quadrant chosen by `cfg_quad`, which covers bus bits `cfg_quad*8` to `cfg_quad*8+7`. Within that quadrant, each select field names the bit index. Activity on the other quadrants has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_bus | input | 32 | Shared control bus, four quadrants of 8 bits |
| cfg_quad | input | 2 | Quadrant serving this cell |
| cfg_mode | input | 3 | Cell mode: 0 comb in, 1 comb out, 2 reg in, 3 reg out, 4 bidir |
| cfg_latch | input | 1 | 0 edge register, 1 transparent latch |
| cfg_clk_sel | input | 3 | Bit index of the clock within the quadrant |
| cfg_clk_inv | input | 1 | Clock inversion |
| cfg_ce_sel | input | 3 | Bit index of the clock enable |
| cfg_ce_inv | input | 1 | Clock enable inversion |
| cfg_oe_sel | input | 3 | Bit index of the output enable |
| cfg_oe_inv | input | 1 | Output enable inversion |
| cfg_rst_sel | input | 3 | Bit index of the reset |
| cfg_rst_inv | input | 1 | Reset inversion |
| cfg_pre_sel | input | 3 | Bit index of the preset |
| cfg_pre_inv | input | 1 | Preset inversion |
| core_out | input | 1 | Value from core logic toward the pad |
| core_in | output | 1 | Value from the cell toward core logic |
| pad_in | input | 1 | Value seen at the pin |
| pad_out | output | 1 | Value driven onto the pin |
| pad_oe | output | 1 | Pin driver enable |

## Verification
The hardest state to reach is a change of every inversion bit, or a move to a new quadrant, without any effective control function changing at all. If any of them moved, a stray clock edge or reset would occur. The bench keeps the intended effective level of every function and rewrites each bus bit as that level XOR the new inversion bit, all in the same step. It does this with reset asserted across the switch between register and latch. After the quadrant move, the unused quadrants are filled with random bits on every cycle. The reference model works from the intended effective levels only, so a wrong bit index or inversion shows up as a mismatch. The bench never releases reset while preset is still asserted.

// File: rtl/io_cell.sv
module io_cell #(
  parameter int QUADS  = 4,
  parameter int CTRL_W = 8,
  localparam int SEL_W = $clog2(CTRL_W),
  localparam int QW    = (QUADS > 1) ? $clog2(QUADS) : 1
) (
  input  logic [QUADS*CTRL_W-1:0] ctrl_bus,
  input  logic [QW-1:0]           cfg_quad,
  input  logic [2:0]              cfg_mode,
  input  logic                    cfg_latch,
  input  logic [SEL_W-1:0]        cfg_clk_sel,
  input  logic                    cfg_clk_inv,
  input  logic [SEL_W-1:0]        cfg_ce_sel,
  input  logic                    cfg_ce_inv,
  input  logic [SEL_W-1:0]        cfg_oe_sel,
  input  logic                    cfg_oe_inv,
  input  logic [SEL_W-1:0]        cfg_rst_sel,
  input  logic                    cfg_rst_inv,
  input  logic [SEL_W-1:0]        cfg_pre_sel,
  input  logic                    cfg_pre_inv,
  input  logic                    core_out,
  output logic                    core_in,
  input  logic                    pad_in,
  output logic                    pad_out,
  output logic                    pad_oe
);

  localparam logic [2:0] M_CIN  = 3'd0;
  localparam logic [2:0] M_COUT = 3'd1;
  localparam logic [2:0] M_RIN  = 3'd2;
  localparam logic [2:0] M_ROUT = 3'd3;
  localparam logic [2:0] M_BIDI = 3'd4;

  logic [CTRL_W-1:0] quad_bus;
  logic clk_e, ce_e, oe_e, rst_e, pre_e;
  logic d, q, q_ff, q_lat;

  assign quad_bus = ctrl_bus[cfg_quad*CTRL_W +: CTRL_W];

  assign clk_e = quad_bus[cfg_clk_sel] ^ cfg_clk_inv;
  assign ce_e  = quad_bus[cfg_ce_sel]  ^ cfg_ce_inv;
  assign oe_e  = quad_bus[cfg_oe_sel]  ^ cfg_oe_inv;
  assign rst_e = quad_bus[cfg_rst_sel] ^ cfg_rst_inv;
  assign pre_e = quad_bus[cfg_pre_sel] ^ cfg_pre_inv;

  assign d = (cfg_mode == M_RIN) ? pad_in : core_out;

  always_ff @(posedge clk_e or posedge rst_e or posedge pre_e) begin
    if (rst_e)      q_ff <= 1'b0;
    else if (pre_e) q_ff <= 1'b1;
    else if (ce_e)  q_ff <= d;
  end

  always_latch begin
    if (rst_e)              q_lat = 1'b0;
    else if (pre_e)         q_lat = 1'b1;
    else if (clk_e && ce_e) q_lat = d;
  end

  assign q = cfg_latch ? q_lat : q_ff;

  always_comb begin
    core_in = 1'b0;
    pad_out = 1'b0;
    pad_oe  = 1'b0;
    case (cfg_mode)
      M_COUT: begin pad_out = core_out; pad_oe = oe_e; end
      M_RIN:  core_in = q;
      M_ROUT: begin pad_out = q;        pad_oe = oe_e; end
      M_BIDI: begin core_in = pad_in; pad_out = core_out; pad_oe = oe_e; end
      default: core_in = pad_in;
    endcase
  end

endmodule

// File: rtl/io_cell_chk.sv
module io_cell_chk (
  input logic       clk_e,
  input logic       rst_e,
  input logic       pre_e,
  input logic       q,
  input logic [2:0] cfg_mode,
  input logic       pad_in,
  input logic       pad_out,
  input logic       pad_oe,
  input logic       core_in,
  input logic       core_out
);

  // R1: input modes never drive the pad
  a_r1_input_quiet: assert property (@(posedge clk_e) disable iff (rst_e)
    (cfg_mode == 3'd0 || cfg_mode >= 3'd5) |-> (!pad_oe && !pad_out && core_in == pad_in));

  // R2: combinational output path
  a_r2_comb_out: assert property (@(posedge clk_e) disable iff (rst_e)
    (cfg_mode == 3'd1) |-> (pad_out == core_out && !core_in));

  // R5: bidirectional pin always observable
  a_r5_bidir_in: assert property (@(posedge clk_e) disable iff (rst_e)
    (cfg_mode == 3'd4) |-> (core_in == pad_in && pad_out == core_out));

  // R8: reset forces zero regardless of preset
  always @(negedge clk_e)
    if (rst_e) a_r8_reset_wins: assert (q == 1'b0);

  // R9: preset alone forces one
  always @(negedge clk_e)
    if (pre_e && !rst_e) a_r9_preset_sets: assert (q == 1'b1);

endmodule

bind io_cell io_cell_chk u_chk (
  .clk_e(clk_e), .rst_e(rst_e), .pre_e(pre_e), .q(q), .cfg_mode(cfg_mode),
  .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
  .core_in(core_in), .core_out(core_out)
);

// File: tb/tb_io_cell.sv
`timescale 1ns/1ps
module tb_io_cell;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] bus = '0;
  logic [2:0]  mode = 3'd2;
  logic        latch = 1'b0;
  logic [2:0]  sel [5] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4};
  bit          inv [5] = '{0, 0, 0, 0, 0};
  bit          eff [5] = '{0, 0, 0, 0, 0};
  int          quad = 0;
  bit          noise = 0;
  logic        core_out = 1'b0, pad_in = 1'b0;
  logic        core_in, pad_out, pad_oe;

  int checks = 0, errors = 0;
  string req = "R8";
  bit mq = 1'b0, pclk = 1'b0;

  io_cell dut (
    .ctrl_bus(bus), .cfg_quad(quad[1:0]), .cfg_mode(mode), .cfg_latch(latch),
    .cfg_clk_sel(sel[0]), .cfg_clk_inv(inv[0]),
    .cfg_ce_sel(sel[1]),  .cfg_ce_inv(inv[1]),
    .cfg_oe_sel(sel[2]),  .cfg_oe_inv(inv[2]),
    .cfg_rst_sel(sel[3]), .cfg_rst_inv(inv[3]),
    .cfg_pre_sel(sel[4]), .cfg_pre_inv(inv[4]),
    .core_out(core_out), .core_in(core_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  // f: 0 clock, 1 enable, 2 output enable, 3 reset, 4 preset
  task automatic setc(input int f, input bit v);
    eff[f] = v;
    bus[quad*8 + int'(sel[f])] = v ^ inv[f];
  endtask

  task automatic redrive();
    for (int f = 0; f < 5; f++) setc(f, eff[f]);
  endtask

  task automatic tick();
    bit md, e_ci, e_po, e_oe;
    @(negedge clk);
    md = (mode == 3'd2) ? pad_in : core_out;
    if (eff[3]) mq = 1'b0;
    else if (eff[4]) mq = 1'b1;
    else if (latch) begin if (eff[0] && eff[1]) mq = md; end
    else if (eff[0] && !pclk && eff[1]) mq = md;
    pclk = eff[0];
    e_ci = 0; e_po = 0; e_oe = 0;
    case (mode)
      3'd1: begin e_po = core_out; e_oe = eff[2]; end
      3'd2: e_ci = mq;
      3'd3: begin e_po = mq; e_oe = eff[2]; end
      3'd4: begin e_ci = pad_in; e_po = core_out; e_oe = eff[2]; end
      default: e_ci = pad_in;
    endcase
    checks++;
    if ({core_in, pad_out, pad_oe} !== {e_ci, e_po, e_oe}) begin
      errors++;
      $display("FAIL %s: {core_in,pad_out,pad_oe} actual=%b expected=%b at %0t",
               req, {core_in, pad_out, pad_oe}, {e_ci, e_po, e_oe}, $time);
    end
    @(posedge clk);
    #1;
    if (noise)
      for (int k = 0; k < 4; k++)
        if (k != quad) bus[k*8 +: 8] = 8'($urandom);
  endtask

  task automatic pulse(input bit v);
    setc(0, 0);
    if (mode == 3'd2) pad_in = v; else core_out = v;
    tick();
    setc(0, 1);
    tick();
  endtask

  initial begin
    @(posedge clk); #1;
    setc(1, 1); setc(3, 1);
    req = "R8"; tick(); tick();
    setc(3, 0); tick();

    req = "R3";
    foreach (sel[i]) ;
    for (int i = 0; i < 6; i++) begin
      pulse(i[0] ^ i[1]);
      pad_in = ~pad_in; tick();
    end

    req = "R7";
    setc(0, 0); setc(1, 0); pad_in = ~mq; tick();
    setc(0, 1); tick();
    setc(0, 0); tick();
    setc(1, 1); tick();

    req = "R1";
    for (int i = 0; i < 6; i++) begin
      mode = (i < 3) ? 3'd0 : 3'(5 + i - 3);
      pad_in = i[0]; core_out = ~i[0]; setc(2, i[1]);
      tick();
    end

    req = "R2"; mode = 3'd1;
    for (int i = 0; i < 4; i++) begin
      core_out = i[0]; setc(2, i[1]); pad_in = i[1]; tick();
    end

    req = "R4"; mode = 3'd3;
    for (int i = 0; i < 5; i++) begin
      setc(2, i[0]); pulse(~i[0] ^ i[1]);
      core_out = ~core_out; tick();
    end

    req = "R5"; mode = 3'd4;
    for (int i = 0; i < 6; i++) begin
      pad_in = i[0]; core_out = i[1]; setc(2, i[2] | i[0]); tick();
    end

    req = "R9"; mode = 3'd3; setc(0, 0); core_out = 0; tick();
    setc(4, 1); tick();
    core_out = 1; tick();
    req = "R8"; setc(3, 1); tick();
    setc(4, 0); tick();
    setc(3, 0); tick();

    req = "R6";
    setc(3, 1); latch = 1; tick();
    setc(3, 0); tick();
    setc(0, 1); core_out = 1; tick();
    core_out = 0; tick();
    core_out = 1; tick();
    setc(0, 0); tick();
    core_out = 0; tick();
    setc(1, 0); setc(0, 1); tick();
    core_out = 1; tick();
    setc(1, 1); tick();
    setc(0, 0); tick();
    setc(3, 1); latch = 0; tick();
    setc(3, 0); tick();

    req = "R10";
    for (int f = 0; f < 5; f++) inv[f] = 1;
    redrive(); tick();
    for (int i = 0; i < 4; i++) begin setc(2, i[0]); pulse(i[1] ^ 1'b1); end
    setc(4, 1); tick();
    setc(4, 0); tick();
    pulse(0);

    req = "R11";
    setc(0, 0); tick();
    quad = 2; sel = '{3'd5, 3'd7, 3'd0, 3'd2, 3'd6};
    redrive(); noise = 1; tick();
    for (int i = 0; i < 5; i++) begin setc(2, i[0]); pulse(i[0] ^ i[2]); end
    setc(0, 0); tick();
    mode = 3'd4;
    for (int i = 0; i < 6; i++) begin pad_in = i[0]; core_out = i[1]; tick(); end
    mode = 3'd3;
    for (int i = 0; i < 5; i++) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule